// File: doc/BRIEF.md
# Flash Section Access Protection Unit

This unit sits beside a flash controller and decides, for each flash access, whether it may proceed. Two configuration bytes, each counting 256-byte blocks, split the flash into three regions: a boot region at the bottom, then an application-code region, then an application-data region. Several degenerate settings are resolved into a well-defined map. Every access presents the program counter of the code issuing it, the target address, an access kind and a valid strobe. One clock later the unit returns allow or deny, a violation pulse, and the region code of the target.

Writes follow a one-way hierarchy. Boot code may write to the code and data regions. Code-region code may write only to data. Data-region code may not write to flash at all, and no code may ever write to the boot region. Two sticky protection bits are set through a small register-write port. The boot lock is accepted only from boot code. Once execution has left the boot region, the lock hides the boot region from reads and fetches. The code write-protect bit freezes the code region against all writes.

The access path carries no back-pressure. Every strobe is accepted in the cycle it is high, so no ready signal exists. Each accepted access yields exactly one response, one cycle later, and the response cannot be stalled.

Top module: `fsp_access_guard`

## Requirements
- R1: With boot end B and app end A both nonzero and A > B (after R5), a target in block k (address bits above bit 7) is region 0 (boot) for k < B, 1 (code) for B <= k < A, and 2 (data) for k >= A. The code appears on rsp_region.
- R2: If the effective boot end is 0, every address is region 0.
- R3: If the effective app end is 0 and the boot end is nonzero, blocks from the boot end to the top of flash are region 1, and no address is region 2.
- R4: If the effective app end is nonzero and no greater than the boot end, blocks from the boot end upward are region 2, and no address is region 1.
- R5: A setting whose block count exceeds the flash size in blocks (32 by default) is replaced by its default parameter. Both defaults are 0. A count equal to the size is kept.
- R6: acc_kind encoding: 0 read, 1 fetch, 2 write, 3 reserved. A write to region 0 is always denied. A write to region 1 is allowed only from a region-0 program counter. A write to region 2 is allowed from a region-0 or region-1 program counter. Reserved accesses are always denied.
- R7: Once the write-protect bit is set (reg_wr_data bit 1), every write to region 1 is denied, including writes from boot code.
- R8: A register write with reg_wr_data bit 0 high sets the boot lock only when reg_pc lies in region 0. From any other region the write is ignored. Either bit takes effect from the cycle after the write.
- R9: With the lock set, lock_active rises after the first valid access whose program counter is outside region 0, and it stays high. That access, and every read or fetch of region 0 while lock_active is high, is denied. Before that, boot code may still read region 0.
- R10: boot_lock, app_wp and lock_active are cleared only by reset. Writing zeros does not clear them. All outputs are 0 after reset.
- R11: rsp_valid, rsp_allow, rsp_region and rsp_viol are registered and reflect the access presented in the previous cycle. rsp_viol equals rsp_valid and not rsp_allow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_boot_end | input | 8 | Boot region end, in 256-byte blocks |
| cfg_app_end | input | 8 | Code region end, in 256-byte blocks |
| acc_valid | input | 1 | Access strobe |
| acc_pc | input | ADDR_W | Program counter of the issuing code |
| acc_addr | input | ADDR_W | Target address |
| acc_kind | input | 2 | 0 read, 1 fetch, 2 write, 3 reserved |
| reg_wr_en | input | 1 | Protection register write strobe |
| reg_wr_data | input | 2 | Bit 0 sets the boot lock, bit 1 sets code write-protect |
| reg_pc | input | ADDR_W | Program counter of the register write |
| rsp_valid | output | 1 | Response present |
| rsp_allow | output | 1 | Access allowed |
| rsp_viol | output | 1 | Access denied |
| rsp_region | output | 2 | Target region code |
| boot_lock | output | 1 | Boot lock bit |
| app_wp | output | 1 | Code write-protect bit |
| lock_active | output | 1 | Lock in force |

## Verification
Two functions can act in the same cycle: a register write that sets the boot lock, and an access that reads the boot region from outside it. The bench issues both in one cycle and expects the access to be allowed with lock_active still low, because the lock bit is not yet visible. The next such access must then be denied and must raise lock_active. The bench applies the same one-cycle-late rule to the write-protect bit against a boot-code write to the code region.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  typedef enum logic [1:0] {
    REG_BOOT = 2'd0,
    REG_CODE = 2'd1,
    REG_DATA = 2'd2
  } region_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_EXEC  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_RSVD  = 2'd3
  } kind_e;

  localparam int CTL_W      = 2;
  localparam int LOCK_BIT   = 0;
  localparam int WPROT_BIT  = 1;
endpackage

// File: rtl/fsp_region_map.sv
module fsp_region_map #(
  parameter int CFG_W        = 8,
  parameter int CMP_W        = 9,
  parameter int NBLK         = 32,
  parameter int BOOT_DEFAULT = 0,
  parameter int APP_DEFAULT  = 0
) (
  input  logic [CFG_W-1:0] cfg_boot,
  input  logic [CFG_W-1:0] cfg_app,
  output logic [CMP_W-1:0] eff_boot,
  output logic [CMP_W-1:0] eff_app
);
  localparam logic [CMP_W-1:0] LIMIT = CMP_W'(NBLK);

  logic [CMP_W-1:0] wide_boot;
  logic [CMP_W-1:0] wide_app;

  always_comb begin
    wide_boot = CMP_W'(cfg_boot);
    wide_app  = CMP_W'(cfg_app);
    eff_boot  = (wide_boot > LIMIT) ? CMP_W'(BOOT_DEFAULT) : wide_boot;
    eff_app   = (wide_app  > LIMIT) ? CMP_W'(APP_DEFAULT)  : wide_app;
  end
endmodule

// File: rtl/fsp_classify.sv
module fsp_classify
  import fsp_pkg::*;
#(
  parameter int CMP_W = 9
) (
  input  logic [CMP_W-1:0] eff_boot,
  input  logic [CMP_W-1:0] eff_app,
  input  logic [CMP_W-1:0] blk,
  output region_e          region
);
  always_comb begin
    if (eff_boot == '0)          region = REG_BOOT;
    else if (blk < eff_boot)     region = REG_BOOT;
    else if (eff_app == '0)      region = REG_CODE;
    else if (eff_app <= eff_boot) region = REG_DATA;
    else if (blk < eff_app)      region = REG_CODE;
    else                         region = REG_DATA;
  end
endmodule

// File: rtl/fsp_lock_regs.sv
module fsp_lock_regs
  import fsp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [CTL_W-1:0] reg_wr_data,
  input  logic             reg_from_boot,
  input  logic             acc_valid,
  input  logic             pc_outside_boot,
  output logic             boot_lock,
  output logic             app_wp,
  output logic             lock_active,
  output logic             lock_now
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_lock   <= 1'b0;
      app_wp      <= 1'b0;
      lock_active <= 1'b0;
    end else begin
      if (reg_wr_en && reg_wr_data[LOCK_BIT] && reg_from_boot) boot_lock <= 1'b1;
      if (reg_wr_en && reg_wr_data[WPROT_BIT])                 app_wp    <= 1'b1;
      if (acc_valid && boot_lock && pc_outside_boot)           lock_active <= 1'b1;
    end
  end

  assign lock_now = lock_active || (boot_lock && pc_outside_boot);

  assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    boot_lock |=> boot_lock);
  assert_wp_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    app_wp |=> app_wp);
  assert_active_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_active |=> lock_active);
  assert_active_needs_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_active |-> boot_lock);
  assert_lock_only_from_boot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_lock && !(reg_wr_en && reg_from_boot)) |=> !boot_lock);
endmodule

// File: rtl/fsp_policy.sv
module fsp_policy
  import fsp_pkg::*;
(
  input  kind_e   kind,
  input  region_e pc_region,
  input  region_e tgt_region,
  input  logic    app_wp,
  input  logic    lock_now,
  output logic    allow
);
  always_comb begin
    allow = 1'b0;
    unique case (kind)
      ACC_WRITE: begin
        unique case (tgt_region)
          REG_CODE: allow = (pc_region == REG_BOOT) && !app_wp;
          REG_DATA: allow = (pc_region != REG_DATA);
          default:  allow = 1'b0;
        endcase
      end
      ACC_READ, ACC_EXEC: allow = !((tgt_region == REG_BOOT) && lock_now);
      default: allow = 1'b0;
    endcase
  end

  always_comb begin
    if (kind == ACC_WRITE && tgt_region == REG_BOOT)
      assert_no_boot_write_R6: assert (!allow);
    if (kind == ACC_WRITE && tgt_region == REG_CODE && app_wp)
      assert_wp_blocks_code_R7: assert (!allow);
  end
endmodule

// File: rtl/fsp_access_guard.sv
module fsp_access_guard
  import fsp_pkg::*;
#(
  parameter int FLASH_BYTES  = 8192,
  parameter int BLOCK_BYTES  = 256,
  parameter int CFG_W        = 8,
  parameter int BOOT_DEFAULT = 0,
  parameter int APP_DEFAULT  = 0,
  localparam int ADDR_W      = $clog2(FLASH_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_boot_end,
  input  logic [CFG_W-1:0]  cfg_app_end,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_pc,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_kind,
  input  logic              reg_wr_en,
  input  logic [CTL_W-1:0]  reg_wr_data,
  input  logic [ADDR_W-1:0] reg_pc,
  output logic              rsp_valid,
  output logic              rsp_allow,
  output logic              rsp_viol,
  output logic [1:0]        rsp_region,
  output logic              boot_lock,
  output logic              app_wp,
  output logic              lock_active
);
  localparam int BLK_SHIFT = $clog2(BLOCK_BYTES);
  localparam int NBLK      = FLASH_BYTES / BLOCK_BYTES;
  localparam int BIDX_W    = ADDR_W - BLK_SHIFT;
  localparam int CMP_W     = ((BIDX_W > CFG_W) ? BIDX_W : CFG_W) + 1;
  localparam int NSRC      = 3;
  localparam int SRC_PC    = 0;
  localparam int SRC_TGT   = 1;
  localparam int SRC_REG   = 2;

  logic [CMP_W-1:0] eff_boot;
  logic [CMP_W-1:0] eff_app;
  logic [CMP_W-1:0] src_blk [NSRC];
  region_e          src_region [NSRC];
  logic             lock_now;
  logic             allow_d;

  fsp_region_map #(
    .CFG_W(CFG_W), .CMP_W(CMP_W), .NBLK(NBLK),
    .BOOT_DEFAULT(BOOT_DEFAULT), .APP_DEFAULT(APP_DEFAULT)
  ) map_i (
    .cfg_boot(cfg_boot_end), .cfg_app(cfg_app_end),
    .eff_boot(eff_boot), .eff_app(eff_app)
  );

  assign src_blk[SRC_PC]  = CMP_W'(acc_pc[ADDR_W-1:BLK_SHIFT]);
  assign src_blk[SRC_TGT] = CMP_W'(acc_addr[ADDR_W-1:BLK_SHIFT]);
  assign src_blk[SRC_REG] = CMP_W'(reg_pc[ADDR_W-1:BLK_SHIFT]);

  for (genvar g = 0; g < NSRC; g++) begin : g_cls
    fsp_classify #(.CMP_W(CMP_W)) cls_i (
      .eff_boot(eff_boot), .eff_app(eff_app),
      .blk(src_blk[g]), .region(src_region[g])
    );
  end

  fsp_lock_regs lock_i (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_from_boot(src_region[SRC_REG] == REG_BOOT),
    .acc_valid(acc_valid),
    .pc_outside_boot(src_region[SRC_PC] != REG_BOOT),
    .boot_lock(boot_lock), .app_wp(app_wp),
    .lock_active(lock_active), .lock_now(lock_now)
  );

  fsp_policy pol_i (
    .kind(kind_e'(acc_kind)),
    .pc_region(src_region[SRC_PC]),
    .tgt_region(src_region[SRC_TGT]),
    .app_wp(app_wp), .lock_now(lock_now),
    .allow(allow_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_allow  <= 1'b0;
      rsp_viol   <= 1'b0;
      rsp_region <= 2'd0;
    end else begin
      rsp_valid  <= acc_valid;
      rsp_allow  <= acc_valid && allow_d;
      rsp_viol   <= acc_valid && !allow_d;
      rsp_region <= acc_valid ? src_region[SRC_TGT] : 2'd0;
    end
  end

  assert_boot_write_denied_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == ACC_WRITE && src_region[SRC_TGT] == REG_BOOT)
      |=> (rsp_valid && !rsp_allow && rsp_viol));
  assert_data_pc_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == ACC_WRITE && src_region[SRC_PC] == REG_DATA) |=> !rsp_allow);
  assert_locked_boot_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && lock_active && acc_kind != ACC_WRITE && src_region[SRC_TGT] == REG_BOOT)
      |=> rsp_viol);
  assert_one_response_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> (rsp_valid && (rsp_allow != rsp_viol)));
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (!rsp_valid && !rsp_allow && !rsp_viol));
endmodule

// File: tb/fsp_access_guard_tb_top.sv
`timescale 1ns/1ps
module fsp_access_guard_tb_top;
  localparam int AW = 13;
  localparam int NB = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cfg_boot_end = '0, cfg_app_end = '0;
  logic acc_valid = 1'b0;
  logic [AW-1:0] acc_pc = '0, acc_addr = '0, reg_pc = '0;
  logic [1:0] acc_kind = '0, reg_wr_data = '0;
  logic reg_wr_en = 1'b0;
  logic rsp_valid, rsp_allow, rsp_viol, boot_lock, app_wp, lock_active;
  logic [1:0] rsp_region;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fsp_access_guard dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_boot_end(cfg_boot_end), .cfg_app_end(cfg_app_end),
    .acc_valid(acc_valid), .acc_pc(acc_pc), .acc_addr(acc_addr), .acc_kind(acc_kind),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_pc(reg_pc),
    .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_viol(rsp_viol),
    .rsp_region(rsp_region), .boot_lock(boot_lock), .app_wp(app_wp),
    .lock_active(lock_active)
  );

  task automatic check(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  function automatic int eregion(int b, int a, int k);
    int eb = (b > NB) ? 0 : b;
    int ea = (a > NB) ? 0 : a;
    if (eb == 0) return 0;
    if (k < eb) return 0;
    if (ea == 0) return 1;
    if (ea <= eb) return 2;
    if (k < ea) return 1;
    return 2;
  endfunction

  function automatic int eallow(int kind, int pr, int tr, int wp, int lk);
    if (kind == 3) return 0;
    if (kind == 2) begin
      if (tr == 0) return 0;
      if (tr == 1) return (pr == 0 && wp == 0) ? 1 : 0;
      return (pr != 2) ? 1 : 0;
    end
    return (tr == 0 && lk != 0) ? 0 : 1;
  endfunction

  function automatic logic [AW-1:0] baddr(int k);
    return AW'(k * 256 + ((k * 37) % 256));
  endfunction

  task automatic do_reset();
    acc_valid = 0; reg_wr_en = 0; reg_wr_data = 0;
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  // presents one access at a negedge, samples its response at the next negedge
  task automatic access(int pck, int tk, int kind);
    acc_valid = 1; acc_pc = baddr(pck); acc_addr = baddr(tk); acc_kind = 2'(kind);
    @(negedge clk);
  endtask

  task automatic regwr(int pck, int data);
    reg_wr_en = 1; reg_wr_data = 2'(data); reg_pc = baddr(pck);
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic expect_acc(string tag, int pck, int tk, int kind, int exp_allow);
    access(pck, tk, kind);
    check({tag, " allow"}, int'(rsp_allow), exp_allow);
    check({tag, " viol"}, int'(rsp_viol), 1 - exp_allow);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: got=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R10 reset state
    check("R10 rsp_valid", int'(rsp_valid), 0);
    check("R10 rsp_allow", int'(rsp_allow), 0);
    check("R10 boot_lock", int'(boot_lock), 0);
    check("R10 app_wp", int'(app_wp), 0);
    check("R10 lock_active", int'(lock_active), 0);

    // R1 R2 R3 R4 R5 region sweep, reads from boot-start pc, no lock
    for (int b = 0; b <= NB + 2; b++) begin
      for (int a = 0; a <= NB + 2; a++) begin
        cfg_boot_end = 8'(b); cfg_app_end = 8'(a);
        for (int k = 0; k < NB; k++) begin
          access(0, k, 0);
          check($sformatf("R1 region b=%0d a=%0d k=%0d", b, a, k),
                int'(rsp_region), eregion(b, a, k));
          check("R11 rsp_valid", int'(rsp_valid), 1);
        end
      end
    end
    acc_valid = 0;
    @(negedge clk);
    check("R11 idle rsp_valid", int'(rsp_valid), 0);
    check("R11 idle rsp_viol", int'(rsp_viol), 0);

    // R6 permission sweep, then R7 with write-protect set
    cfg_boot_end = 8'd4; cfg_app_end = 8'd8;
    for (int wp = 0; wp < 2; wp++) begin
      do_reset();
      if (wp == 1) begin
        regwr(20, 2);
        check("R7 app_wp set", int'(app_wp), 1);
      end
      for (int p = 0; p < NB; p++)
        for (int t = 0; t < NB; t++)
          for (int kd = 0; kd < 4; kd++) begin
            access(p, t, kd);
            check($sformatf("R6 R7 wp=%0d p=%0d t=%0d k=%0d", wp, p, t, kd),
                  int'(rsp_allow), eallow(kd, eregion(4, 8, p), eregion(4, 8, t), wp, 0));
          end
      acc_valid = 0;
      @(negedge clk);
      check("R9 no lock stays idle", int'(lock_active), 0);
    end

    // R8 lock write from non-boot pc is ignored
    do_reset();
    regwr(5, 1);
    check("R8 lock from code ignored", int'(boot_lock), 0);
    expect_acc("R8 boot read from code pc", 5, 1, 0, 1);
    regwr(9, 1);
    check("R8 lock from data ignored", int'(boot_lock), 0);
    // R8 lock from boot pc
    acc_valid = 0;
    regwr(2, 1);
    check("R8 lock from boot", int'(boot_lock), 1);
    check("R8 write-protect untouched", int'(app_wp), 0);
    // R9 still inside boot: allowed
    expect_acc("R9 boot read before leaving", 1, 0, 0, 1);
    check("R9 active low in boot", int'(lock_active), 0);
    expect_acc("R9 first outside access denied", 6, 2, 1, 0);
    check("R9 active after leaving", int'(lock_active), 1);
    expect_acc("R9 boot read from boot after active", 1, 0, 0, 0);
    expect_acc("R9 boot fetch from boot after active", 3, 3, 1, 0);
    expect_acc("R9 code read still allowed", 1, 5, 0, 1);
    expect_acc("R9 boot-pc write to data allowed", 1, 12, 2, 1);
    acc_valid = 0;
    // R10 writing zeros has no effect
    regwr(0, 0);
    check("R10 lock stays", int'(boot_lock), 1);
    check("R10 active stays", int'(lock_active), 1);
    do_reset();
    check("R10 reset clears lock", int'(boot_lock), 0);
    check("R10 reset clears active", int'(lock_active), 0);

    // Same cycle: lock write from boot plus boot read from code pc
    reg_wr_en = 1; reg_wr_data = 2'd1; reg_pc = baddr(0);
    access(5, 0, 0);
    reg_wr_en = 0;
    check("R8 same-cycle access allowed", int'(rsp_allow), 1);
    check("R9 same-cycle active low", int'(lock_active), 0);
    check("R8 lock set after write", int'(boot_lock), 1);
    expect_acc("R9 next outside read denied", 5, 0, 0, 0);
    check("R9 active raised", int'(lock_active), 1);

    // Same cycle: write-protect set plus boot-code write to code region
    do_reset();
    reg_wr_en = 1; reg_wr_data = 2'd2; reg_pc = baddr(7);
    access(0, 5, 2);
    reg_wr_en = 0;
    check("R7 same-cycle write allowed", int'(rsp_allow), 1);
    expect_acc("R7 next code write denied", 0, 5, 2, 0);
    expect_acc("R7 data write allowed", 0, 20, 2, 1);
    acc_valid = 0;
    regwr(7, 0);
    check("R10 wp stays after zero write", int'(app_wp), 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule